// File: doc/BRIEF.md
# XT Keyboard Host Receiver

This block is the host end of the XT keyboard link. It watches the keyboard's open-drain clock and data lines through two-flop synchronisers and reacts to each falling edge of the clock. A frame opens with a start bit at 1 and carries eight further bits, least significant first. The low seven bits are the key code and bit 7 is the release flag. When the ninth bit arrives, the byte goes to `rxByte`, `rxFull` rises, and the block pulls the keyboard clock low so that the keyboard cannot send again. The line stays low until the CPU side gives a one-cycle `readAck`.

A one-cycle `resetReq` makes the block hold the keyboard clock low for `RESET_CYCLES` system clocks, which resets the keyboard. The request throws away any pending byte or partial frame. A keyboard that has reset announces itself with the byte 0xAA, and receiving that byte sets the sticky `kbdReady` flag. A frame that stops making progress for `TIMEOUT_CYCLES` is dropped and raises `frameErr`.

Top module: `xt_kbd_host_rx`

## Requirements
- R1: Both input lines pass through two synchronising flops. A bit is taken only on a 1-to-0 transition of the synchronised keyboard clock, and the value taken is the synchronised data line at that moment.
- R2: After a start bit, the next eight captured bits form `rxByte`, the first one landing in bit 0 and the last one in bit 7. The byte appears together with `rxFull` = 1 and does not change while `rxFull` stays 1.
- R3: From the cycle in which `rxFull` rises until the byte is acknowledged, `kbdClkLowOut` is 1, meaning the keyboard clock is pulled low.
- R4: A one-cycle `readAck` while `rxFull` is 1 clears `rxFull` and releases the clock on the next cycle. `readAck` also clears `frameErr`.
- R5: `kbdClkLowOut` is 0 whenever no byte is pending and no reset hold is running, including straight after the block's own reset.
- R6: `resetReq` pulls the clock low for exactly `RESET_CYCLES` cycles, starting in the next cycle, and discards any pending byte or partial frame. `resetReq` takes priority over `readAck`.
- R7: A received byte equal to 0xAA sets `kbdReady`. The flag then stays set until a `resetReq` clears it, which takes effect on the next cycle.
- R8: A falling edge with data 0 while waiting for a start bit is ignored. The frame that follows is received unchanged.
- R9: A frame that sees no falling clock edge for `TIMEOUT_CYCLES` cycles after its last bit is discarded. In that case `frameErr` is set and `rxFull` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| kbdClkIn | input | 1 | Sensed keyboard clock line |
| kbdDataIn | input | 1 | Sensed keyboard data line |
| readAck | input | 1 | One-cycle acknowledge of the pending byte |
| resetReq | input | 1 | One-cycle request for a keyboard reset |
| kbdClkLowOut | output | 1 | 1 = pull the keyboard clock line low |
| rxByte | output | 8 | Last received byte |
| rxFull | output | 1 | A byte is waiting to be read |
| frameErr | output | 1 | A partial frame timed out |
| kbdReady | output | 1 | 0xAA seen since the last reset request |

## Verification
The bench builds the block with `RESET_CYCLES` = 64 and `TIMEOUT_CYCLES` = 60. These values are far below the defaults of about 20 ms and 1 ms. With them, the exact length of the reset hold can be counted cycle by cycle, and a stalled frame can be made to time out within a short run. The keyboard bit period of 11 cycles remains well inside the timeout, so normal frames never trip it.

// File: rtl/xt_kbd_rx_pkg.sv
package xt_kbd_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_FULL = 2'd2,
    ST_RST  = 2'd3
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftBit;
    logic loadByte;
    logic clearFull;
    logic setErr;
    logic clearErr;
    logic clearReady;
  } rxCtrl_t;

endpackage

// File: rtl/xt_kbd_rx_datapath.sv
module xt_kbd_rx_datapath
  import xt_kbd_rx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] READY_CODE = 8'hAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              kbdClkIn,
  input  logic              kbdDataIn,
  input  rxCtrl_t           ctrl,
  output logic              fallEdge,
  output logic              dataBit,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxFull,
  output logic              frameErr,
  output logic              kbdReady
);

  logic [1:0]        clkSync;
  logic [1:0]        dataSync;
  logic              clkPrev;
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] assembled;

  // two-flop synchronisers; clock idles high, data idles low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync  <= 2'b11;
      dataSync <= 2'b00;
      clkPrev  <= 1'b1;
    end else begin
      clkSync  <= {clkSync[0], kbdClkIn};
      dataSync <= {dataSync[0], kbdDataIn};
      clkPrev  <= clkSync[1];
    end
  end

  assign fallEdge  = clkPrev & ~clkSync[1];
  assign dataBit   = dataSync[1];
  assign assembled = {dataBit, shiftReg[BYTE_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxByte   <= '0;
    end else begin
      if (ctrl.shiftBit) shiftReg <= assembled;
      if (ctrl.loadByte) rxByte   <= assembled;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull   <= 1'b0;
      frameErr <= 1'b0;
      kbdReady <= 1'b0;
    end else begin
      if (ctrl.clearFull)     rxFull <= 1'b0;
      else if (ctrl.loadByte) rxFull <= 1'b1;

      if (ctrl.setErr)        frameErr <= 1'b1;
      else if (ctrl.clearErr) frameErr <= 1'b0;

      if (ctrl.clearReady)    kbdReady <= 1'b0;
      else if (ctrl.loadByte && assembled == READY_CODE) kbdReady <= 1'b1;
    end
  end

endmodule

// File: rtl/xt_kbd_rx_control.sv
module xt_kbd_rx_control
  import xt_kbd_rx_pkg::*;
#(
  parameter int BYTE_W         = 8,
  parameter int RESET_CYCLES   = 5000000,
  parameter int TIMEOUT_CYCLES = 250000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    fallEdge,
  input  logic    dataBit,
  input  logic    readAck,
  input  logic    resetReq,
  output rxCtrl_t ctrl,
  output logic    kbdClkLowOut
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam int RST_W = $clog2(RESET_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [TMR_W-1:0] TMR_END  = TMR_W'(TIMEOUT_CYCLES - 1);
  localparam logic [RST_W-1:0] RST_END  = RST_W'(RESET_CYCLES - 1);

  rxState_t         state, nextState;
  logic [CNT_W-1:0] bitCnt;
  logic [TMR_W-1:0] stallTmr;
  logic [RST_W-1:0] holdCnt;

  always_comb begin
    ctrl      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (fallEdge && dataBit) nextState = ST_RECV;
      ST_RECV: begin
        if (fallEdge) begin
          ctrl.shiftBit = 1'b1;
          if (bitCnt == LAST_BIT) begin
            ctrl.loadByte = 1'b1;
            nextState     = ST_FULL;
          end
        end else if (stallTmr == TMR_END) begin
          ctrl.setErr = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      ST_FULL: if (readAck) begin
        ctrl.clearFull = 1'b1;
        nextState      = ST_IDLE;
      end
      ST_RST:  if (holdCnt == RST_END) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
    if (readAck) ctrl.clearErr = 1'b1;
    if (resetReq) begin
      ctrl            = '0;
      ctrl.clearFull  = 1'b1;
      ctrl.clearErr   = 1'b1;
      ctrl.clearReady = 1'b1;
      nextState       = ST_RST;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      stallTmr <= '0;
      holdCnt  <= '0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE)   bitCnt <= '0;
      else if (ctrl.shiftBit) bitCnt <= bitCnt + 1'b1;
      if (state != ST_RECV || fallEdge) stallTmr <= '0;
      else                              stallTmr <= stallTmr + 1'b1;
      if (resetReq)             holdCnt <= '0;
      else if (state == ST_RST) holdCnt <= holdCnt + 1'b1;
    end
  end

  assign kbdClkLowOut = (state == ST_FULL) || (state == ST_RST);

endmodule

// File: rtl/xt_kbd_host_rx.sv
module xt_kbd_host_rx
  import xt_kbd_rx_pkg::*;
#(
  parameter int RESET_CYCLES   = 5000000,
  parameter int TIMEOUT_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       kbdClkIn,
  input  logic       kbdDataIn,
  input  logic       readAck,
  input  logic       resetReq,
  output logic       kbdClkLowOut,
  output logic [7:0] rxByte,
  output logic       rxFull,
  output logic       frameErr,
  output logic       kbdReady
);

  localparam int BYTE_W = 8;

  rxCtrl_t ctrl;
  logic    fallEdge;
  logic    dataBit;

  xt_kbd_rx_datapath #(.BYTE_W(BYTE_W), .READY_CODE(8'hAA)) datapath_i (
    .clk(clk), .rstN(rstN), .kbdClkIn(kbdClkIn), .kbdDataIn(kbdDataIn),
    .ctrl(ctrl), .fallEdge(fallEdge), .dataBit(dataBit), .rxByte(rxByte),
    .rxFull(rxFull), .frameErr(frameErr), .kbdReady(kbdReady)
  );

  xt_kbd_rx_control #(
    .BYTE_W(BYTE_W), .RESET_CYCLES(RESET_CYCLES), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) control_i (
    .clk(clk), .rstN(rstN), .fallEdge(fallEdge), .dataBit(dataBit),
    .readAck(readAck), .resetReq(resetReq), .ctrl(ctrl),
    .kbdClkLowOut(kbdClkLowOut)
  );

endmodule

// File: rtl/xt_kbd_host_rx_chk.sv
module xt_kbd_host_rx_chk #(
  parameter int RESET_CYCLES = 5000000
) (
  input logic       clk,
  input logic       rstN,
  input logic       readAck,
  input logic       resetReq,
  input logic       kbdClkLowOut,
  input logic [7:0] rxByte,
  input logic       rxFull,
  input logic       kbdReady
);

  localparam int HW = $clog2(RESET_CYCLES + 1);
  logic [HW-1:0] holdLeft;

  // independent count of the reset hold window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              holdLeft <= '0;
    else if (resetReq)      holdLeft <= HW'(RESET_CYCLES);
    else if (holdLeft != 0) holdLeft <= holdLeft - 1'b1;
  end

  p_clk_held_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxFull |-> kbdClkLowOut);

  p_byte_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !readAck && !resetReq) |=> $stable(rxByte));

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && readAck) |=> !rxFull);

  p_hold_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (holdLeft != 0) |-> kbdClkLowOut);

  p_release_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (holdLeft == 0 && !rxFull) |-> !kbdClkLowOut);

  p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !kbdReady);

endmodule

bind xt_kbd_host_rx xt_kbd_host_rx_chk #(.RESET_CYCLES(RESET_CYCLES)) chk_i (
  .clk(clk), .rstN(rstN), .readAck(readAck), .resetReq(resetReq),
  .kbdClkLowOut(kbdClkLowOut), .rxByte(rxByte), .rxFull(rxFull),
  .kbdReady(kbdReady)
);

// File: tb/xt_kbd_host_rx_tb_top.sv
`timescale 1ns/1ps
module xt_kbd_host_rx_tb_top;

  localparam int RST_CYC = 64;
  localparam int TMO_CYC = 60;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic kbClk = 1'b1, kbData = 1'b0;
  logic readAck = 1'b0, resetReq = 1'b0;
  logic kbdClkLowOut, rxFull, frameErr, kbdReady;
  logic [7:0] rxByte;
  logic lineClk;

  int errors = 0, checks = 0;
  logic [7:0] expQ[$];
  bit autoAck = 1'b1;

  always #2 clk = ~clk;
  assign lineClk = kbClk & ~kbdClkLowOut;   // open-drain wired clock

  xt_kbd_host_rx #(.RESET_CYCLES(RST_CYC), .TIMEOUT_CYCLES(TMO_CYC)) dut_i (
    .clk(clk), .rstN(rstN), .kbdClkIn(lineClk), .kbdDataIn(kbData),
    .readAck(readAck), .resetReq(resetReq), .kbdClkLowOut(kbdClkLowOut),
    .rxByte(rxByte), .rxFull(rxFull), .frameErr(frameErr), .kbdReady(kbdReady)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // keyboard model: waits for a released clock, then sends nBits bits
  task automatic sendBits(input logic startBit, input logic [7:0] b,
                          input int nBits, input bit push);
    while (kbdClkLowOut) @(negedge clk);
    repeat (4) @(negedge clk);
    if (push) expQ.push_back(b);
    for (int i = 0; i < nBits; i++) begin
      kbData = (i == 0) ? startBit : b[i-1];
      repeat (3) @(negedge clk);
      kbClk = 1'b0;
      repeat (4) @(negedge clk);
      kbClk = 1'b1;
      repeat (4) @(negedge clk);
    end
    kbData = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0 || rxFull) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    logic seen = 1'b0;
    forever begin
      @(negedge clk);
      if (rxFull && !seen) begin
        if (expQ.size() == 0) check("R2 unexpected byte", rxByte, 32'hFFFF);
        else check("R1 R2 byte", rxByte, expQ.pop_front());
        check("R3 clock held while full", kbdClkLowOut, 1);
        if (autoAck) begin
          readAck = 1'b1;
          @(negedge clk);
          readAck = 1'b0;
          check("R4 full cleared", rxFull, 0);
          check("R4 clock released", kbdClkLowOut, 0);
        end
      end
      seen = rxFull;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finishRun();
  end

  initial begin
    int lowCnt;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R5 reset clock released", kbdClkLowOut, 0);
    check("R2 reset full", rxFull, 0);
    check("R9 reset err", frameErr, 0);
    check("R7 reset ready", kbdReady, 0);

    sendBits(1'b1, 8'h1E, 9, 1'b1);
    sendBits(1'b1, 8'h9E, 9, 1'b1);
    sendBits(1'b1, 8'h55, 9, 1'b1);
    drain();
    check("R7 ready before AA", kbdReady, 0);
    sendBits(1'b1, 8'hAA, 9, 1'b1);
    drain();
    check("R7 ready after AA", kbdReady, 1);
    sendBits(1'b1, 8'h01, 9, 1'b1);
    drain();
    check("R7 ready sticky", kbdReady, 1);

    // R8: stray edge with data 0
    sendBits(1'b0, 8'h00, 1, 1'b0);
    repeat (10) @(negedge clk);
    check("R8 no frame from zero start", rxFull, 0);
    sendBits(1'b1, 8'h3C, 9, 1'b1);
    drain();

    // R9: stalled frame
    sendBits(1'b1, 8'h07, 4, 1'b0);
    repeat (TMO_CYC + 20) @(negedge clk);
    check("R9 frame error set", frameErr, 1);
    check("R9 no byte", rxFull, 0);
    check("R5 released after timeout", kbdClkLowOut, 0);
    sendBits(1'b1, 8'h42, 9, 1'b1);
    drain();
    check("R4 ack clears frame error", frameErr, 0);

    // R6: reset request with a pending byte
    autoAck = 1'b0;
    sendBits(1'b1, 8'h77, 9, 1'b1);
    while (!rxFull) @(negedge clk);
    @(negedge clk);
    check("R3 held without ack", kbdClkLowOut, 1);
    resetReq = 1'b1;
    readAck  = 1'b1;
    @(negedge clk);
    resetReq = 1'b0;
    readAck  = 1'b0;
    check("R7 ready cleared", kbdReady, 0);
    check("R6 pending byte dropped", rxFull, 0);
    lowCnt = 0;
    fork
      begin
        for (int i = 0; i < 5; i++) begin
          kbData = 1'b1;
          repeat (4) @(negedge clk);
          kbClk = 1'b0;
          repeat (4) @(negedge clk);
          kbClk = 1'b1;
        end
        kbData = 1'b0;
      end
      while (kbdClkLowOut && lowCnt < 1000) begin
        lowCnt++;
        @(negedge clk);
      end
    join
    check("R6 hold length", lowCnt, RST_CYC);
    repeat (10) @(negedge clk);
    check("R6 no byte during hold", rxFull, 0);
    autoAck = 1'b1;
    sendBits(1'b1, 8'hAA, 9, 1'b1);
    drain();
    check("R7 ready after reset", kbdReady, 1);
    finishRun();
  end

endmodule